// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Controller

This block keeps an interrupt-enable register and an interrupt-status register for each of five localities, and drives one interrupt line that all of them share. Event sources pulse a locality index together with a mask of event kinds: data available, status valid, locality changed and command ready. An event is recorded in the status register of its locality, and raises the shared line, only when that locality has its global enable bit set and also enables that event kind.

The host reaches the registers through a plain write strobe and a combinational read port, each addressed by a locality and a register select. Writes to the enable or status register count only when they come from the locality that is currently active. Writing ones to the status register clears those bits. The line drops when such a clear leaves the status of the writing locality at zero. A fixed vector register can be read and ignores writes. Events and writes are always accepted, one of each per cycle. There is no back-pressure, so the block has no valid/ready handshake.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every enable register reads 0x0000_0010 (polarity field, bits 5:4, holds code 01 = low level; global enable and all event enables off), every status register reads 0, and `irq` is low.
- R2: An event whose `evt_loc` is 5 or more (7 means no locality) changes no status register and does not raise `irq`.
- R3: An event bit b (0 data available, 1 status valid, 2 locality changed, 3 command ready) sets status bit b of locality `evt_loc` only when enable bit 31 (global) and enable bit b of that locality are both 1.
- R4: `irq` goes high on the clock edge at which at least one status bit is set by an event.
- R5: An accepted enable write stores `wr_data & 0x8000_003F`: bit 31, the polarity field (bits 5:4) and event enables (bits 3:0) are writable, and all other bits read 0.
- R6: An enable or status write (`wr_sel` 0 or 1) with `wr_loc` different from `active_loc`, or with `active_loc` 5 or more, changes no register.
- R7: An accepted status write (`wr_sel` = 1) clears every status bit whose `wr_data` bit among bits 3:0 is 1. Higher data bits have no effect.
- R8: `irq` drops when an accepted status write clears at least one bit of a nonzero status and leaves that locality's status at zero, even if another locality still holds status bits. A clear that leaves bits set keeps `irq` high.
- R9: The vector register (`wr_sel`/`rd_sel` = 2) reads the constant `VECTOR` parameter (default 0x0000_000B), and writes to it change nothing.
- R10: When an event and an accepted clear hit the same status bit in the same cycle, the bit ends set and `irq` ends high.
- R11: Several event bits in one pulse latch together, each gated by its own enable.
- R12: A read of select 3, or a read with `rd_loc` 5 or more, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | 3 | Currently active locality; 5..7 mean none |
| evt_valid | input | 1 | One-cycle event pulse |
| evt_loc | input | 3 | Locality the event belongs to |
| evt_mask | input | 4 | Event kinds in the pulse |
| wr_en | input | 1 | Host register write strobe |
| wr_loc | input | 3 | Locality of the write |
| wr_sel | input | 2 | 0 enable, 1 status, 2 vector, 3 reserved |
| wr_data | input | 32 | Write data |
| rd_loc | input | 3 | Locality of the read |
| rd_sel | input | 2 | Register select of the read |
| rd_data | output | 32 | Read data, combinational from register state |
| irq | output | 1 | Shared interrupt line, high when asserted |

## Verification
Every register update happens one clock edge after the input that causes it. This holds for status latching, clears and enable writes. `irq` also rises or falls on that same edge. `rd_data` follows register state with no added delay. The bench drives each stimulus on a falling edge. It compares `irq` on the next falling edge, then moves the read port and compares `rd_data` a short delay later, before the next stimulus goes out. Each result is therefore checked exactly one edge after its cause, against a model that is stepped once per cycle.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;

  localparam int EVT_W    = 4;
  localparam int REG_W    = 32;

  // event bit positions, shared by enable bits 3:0 and status bits 3:0
  localparam int EV_DATA   = 0;
  localparam int EV_STSVAL = 1;
  localparam int EV_LOCCHG = 2;
  localparam int EV_CMDRDY = 3;

  localparam int POL_LSB  = 4;
  localparam int GLB_BIT  = 31;

  localparam logic [REG_W-1:0] EN_WMASK = 32'h8000_003F;
  localparam logic [1:0]       POL_LOW_LEVEL = 2'b01;
  localparam logic [REG_W-1:0] EN_RESET =
    REG_W'({POL_LOW_LEVEL, {POL_LSB{1'b0}}});

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/loc_irq_enable_reg.sv
module loc_irq_enable_reg
  import loc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
    end else if (wr_stb) begin
      en_q <= wr_data & EN_WMASK;
    end
  end

endmodule

// File: rtl/loc_irq_status_reg.sv
module loc_irq_status_reg
  import loc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_mask,
  input  logic             clr_stb,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] st_q,
  output logic             drop
);

  logic [EVT_W-1:0] clr_eff;
  logic [EVT_W-1:0] st_nxt;

  always_comb begin
    clr_eff = clr_stb ? clr_mask : '0;
    // a set in the same cycle wins over a clear
    st_nxt  = (st_q & ~clr_eff) | set_mask;
    drop    = clr_stb && (|clr_mask) && (|st_q) && (st_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_nxt;
    end
  end

endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] set_any,
  input  logic [NUM_LOC-1:0] drop_any,
  output logic               line_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else if (|set_any) begin
      line_q <= 1'b1;
    end else if (|drop_any) begin
      line_q <= 1'b0;
    end
  end

endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import loc_irq_pkg::*;
#(
  parameter int              NUM_LOC = 5,
  parameter int              LOC_W   = 3,
  parameter logic [REG_W-1:0] VECTOR = 32'h0000_000B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [EVT_W-1:0] evt_mask,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [LOC_W-1:0] rd_loc,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);

  localparam logic [LOC_W-1:0] LOC_LIMIT = LOC_W'(NUM_LOC);

  logic [REG_W-1:0] en_q [NUM_LOC];
  logic [EVT_W-1:0] st_q [NUM_LOC];
  logic [NUM_LOC-1:0] set_any;
  logic [NUM_LOC-1:0] drop_any;
  logic [NUM_LOC*REG_W-1:0] en_flat;
  logic [NUM_LOC*EVT_W-1:0] st_flat;

  logic     wr_accept;
  reg_sel_e wsel;
  reg_sel_e rsel;

  assign wsel      = reg_sel_e'(wr_sel);
  assign rsel      = reg_sel_e'(rd_sel);
  assign wr_accept = wr_en && (active_loc < LOC_LIMIT) && (wr_loc == active_loc);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    localparam logic [LOC_W-1:0] IDX = LOC_W'(i);
    logic             hit;
    logic             own_wr;
    logic [EVT_W-1:0] set_m;

    assign hit    = evt_valid && (evt_loc == IDX);
    assign own_wr = wr_accept && (wr_loc == IDX);
    assign set_m  = (hit && en_q[i][GLB_BIT]) ? (evt_mask & en_q[i][EVT_W-1:0]) : '0;
    assign set_any[i] = |set_m;

    loc_irq_enable_reg u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (own_wr && (wsel == SEL_ENABLE)),
      .wr_data (wr_data),
      .en_q    (en_q[i])
    );

    loc_irq_status_reg u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_m),
      .clr_stb  (own_wr && (wsel == SEL_STATUS)),
      .clr_mask (wr_data[EVT_W-1:0]),
      .st_q     (st_q[i]),
      .drop     (drop_any[i])
    );

    assign en_flat[i*REG_W +: REG_W] = en_q[i];
    assign st_flat[i*EVT_W +: EVT_W] = st_q[i];
  end

  loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_any  (set_any),
    .drop_any (drop_any),
    .line_q   (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_loc < LOC_LIMIT) begin
      for (int k = 0; k < NUM_LOC; k++) begin
        if (rd_loc == LOC_W'(k)) begin
          case (rsel)
            SEL_ENABLE: rd_data = en_q[k];
            SEL_STATUS: rd_data = REG_W'(st_q[k]);
            SEL_VECTOR: rd_data = VECTOR;
            default:    rd_data = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int EVT_W   = 4,
  parameter int REG_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LOC_W-1:0]         active_loc,
  input logic                     evt_valid,
  input logic [LOC_W-1:0]         evt_loc,
  input logic                     wr_en,
  input logic [LOC_W-1:0]         wr_loc,
  input logic [1:0]               wr_sel,
  input logic                     irq,
  input logic [NUM_LOC*REG_W-1:0] en_flat,
  input logic [NUM_LOC*EVT_W-1:0] st_flat
);

  // R4 / R2: the line only rises after an event for a real locality
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_valid && (evt_loc < LOC_W'(NUM_LOC))));

  // R8: the line only falls after a status write from the active locality
  assert_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && (wr_sel == 2'd1) && (wr_loc == active_loc)));

  // R6: a foreign write with no event leaves all registers alone
  assert_foreign_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel[1] && (wr_loc != active_loc) && !evt_valid)
      |=> ($stable(en_flat) && $stable(st_flat)));

  // R2: without a valid-locality event the line cannot come up
  assert_bad_loc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(evt_valid && (evt_loc < LOC_W'(NUM_LOC)))) |=> !irq);

  // R3: a status bit can rise only if both enables were on
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_chk
    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
      assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_flat[i*EVT_W+b]) |->
          $past(en_flat[i*REG_W+REG_W-1] && en_flat[i*REG_W+b]));
    end
  end

endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active_loc (active_loc),
  .evt_valid  (evt_valid),
  .evt_loc    (evt_loc),
  .wr_en      (wr_en),
  .wr_loc     (wr_loc),
  .wr_sel     (wr_sel),
  .irq        (irq),
  .en_flat    (en_flat),
  .st_flat    (st_flat)
);

// File: tb/test_loc_irq_ctrl.sv
`timescale 1ns/1ps
module test_loc_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  active_loc;
  logic        evt_valid;
  logic [2:0]  evt_loc;
  logic [3:0]  evt_mask;
  logic        wr_en;
  logic [2:0]  wr_loc;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  rd_loc;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_en [5];
  logic [3:0]  m_st [5];
  logic        m_line;

  always #2 clk = ~clk;

  loc_irq_ctrl i_loc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc),
    .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_mask(evt_mask),
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] exp_read(logic [2:0] l, logic [1:0] s);
    if (l >= 3'd5) return 32'h0;                 // R12
    case (s)
      2'd0: return m_en[l];
      2'd1: return {28'h0, m_st[l]};
      2'd2: return 32'h0000_000B;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin
      m_en[i] = 32'h0000_0010;
      m_st[i] = 4'h0;
    end
    m_line = 1'b0;
  endtask

  task automatic model_step();
    bit any_set = 0;
    bit any_drop = 0;
    for (int i = 0; i < 5; i++) begin
      logic [3:0] setm, clr, nst;
      bit acc;
      setm = (evt_valid && evt_loc == 3'(i) && m_en[i][31]) ? (evt_mask & m_en[i][3:0]) : 4'h0;
      acc  = wr_en && active_loc < 3'd5 && wr_loc == active_loc && wr_loc == 3'(i);
      clr  = (acc && wr_sel == 2'd1) ? wr_data[3:0] : 4'h0;
      nst  = (m_st[i] & ~clr) | setm;
      if (acc && wr_sel == 2'd1 && wr_data[3:0] != 0 && m_st[i] != 0 && nst == 0) any_drop = 1;
      if (setm != 0) any_set = 1;
      m_st[i] = nst;
      if (acc && wr_sel == 2'd0) m_en[i] = wr_data & 32'h8000_003F;
    end
    if (any_set) m_line = 1'b1;
    else if (any_drop) m_line = 1'b0;
  endtask

  // drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(string tag, bit ev, logic [2:0] el, logic [3:0] em,
                      bit we, logic [2:0] wl, logic [1:0] ws, logic [31:0] wd,
                      logic [2:0] act);
    evt_valid = ev; evt_loc = el; evt_mask = em;
    wr_en = we; wr_loc = wl; wr_sel = ws; wr_data = wd; active_loc = act;
    model_step();
    @(posedge clk);
    @(negedge clk);
    evt_valid = 0; wr_en = 0;
    check(irq == m_line, tag, {31'h0, irq}, {31'h0, m_line});
  endtask

  task automatic rd(string tag, logic [2:0] l, logic [1:0] s);
    logic [31:0] e;
    rd_loc = l; rd_sel = s;
    #1;
    e = exp_read(l, s);
    check(rd_data == e, tag, rd_data, e);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F3A;
    void'($urandom(seed));
    rst_n = 0; active_loc = 3'd7; evt_valid = 0; evt_loc = 0; evt_mask = 0;
    wr_en = 0; wr_loc = 0; wr_sel = 0; wr_data = 0; rd_loc = 0; rd_sel = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 5; i++) begin
      rd("R1 enable", 3'(i), 2'd0);
      rd("R1 status", 3'(i), 2'd1);
    end
    // R9 vector constant, write ignored; R12 reserved / bad locality
    rd("R9 vector", 3'd2, 2'd2);
    step("R9 vec write", 0, 0, 0, 1, 3'd2, 2'd2, 32'hFFFF_FFFF, 3'd2);
    rd("R9 vector after write", 3'd2, 2'd2);
    rd("R12 reserved sel", 3'd1, 2'd3);
    rd("R12 bad locality", 3'd6, 2'd0);

    // R5 enable write mask
    step("R5 en write", 0, 0, 0, 1, 3'd0, 2'd0, 32'hFFFF_FFFF, 3'd0);
    rd("R5 enable mask", 3'd0, 2'd0);
    // R2 invalid localities ignored
    step("R2 loc5 event", 1, 3'd5, 4'hF, 0, 0, 0, 0, 3'd0);
    step("R2 loc7 event", 1, 3'd7, 4'hF, 0, 0, 0, 0, 3'd0);
    rd("R2 status loc0", 3'd0, 2'd1);
    // R3/R4 gated event latches and raises line
    step("R4 event raise", 1, 3'd0, 4'h1, 0, 0, 0, 0, 3'd0);
    rd("R3 status latched", 3'd0, 2'd1);
    // R3 without global enable nothing latches
    step("R3 en no global", 0, 0, 0, 1, 3'd1, 2'd0, 32'h0000_000F, 3'd1);
    step("R3 event blocked", 1, 3'd1, 4'hF, 0, 0, 0, 0, 3'd1);
    rd("R3 status blocked", 3'd1, 2'd1);
    // R6 foreign writes ignored
    step("R6 foreign clear", 0, 0, 0, 1, 3'd0, 2'd1, 32'hF, 3'd1);
    rd("R6 status kept", 3'd0, 2'd1);
    step("R6 foreign enable", 0, 0, 0, 1, 3'd0, 2'd0, 32'h0, 3'd1);
    rd("R6 enable kept", 3'd0, 2'd0);
    step("R6 none active", 0, 0, 0, 1, 3'd7, 2'd1, 32'hF, 3'd7);
    rd("R6 status kept none", 3'd0, 2'd1);
    // R11 multiple bits, R7 partial clear, R8 drop
    step("R11 multi event", 1, 3'd0, 4'hE, 0, 0, 0, 0, 3'd0);
    rd("R11 status all", 3'd0, 2'd1);
    step("R8 partial clear keeps line", 0, 0, 0, 1, 3'd0, 2'd1, 32'hFFFF_FFF3, 3'd0);
    rd("R7 partial clear", 3'd0, 2'd1);
    step("R8 full clear drops line", 0, 0, 0, 1, 3'd0, 2'd1, 32'h0000_000C, 3'd0);
    rd("R7 cleared", 3'd0, 2'd1);
    // R10 event and clear collide
    step("R10 prime", 1, 3'd0, 4'h1, 0, 0, 0, 0, 3'd0);
    step("R10 collide", 1, 3'd0, 4'h1, 1, 3'd0, 2'd1, 32'h1, 3'd0);
    rd("R10 bit stays", 3'd0, 2'd1);
    // R8 shared line drops on one locality reaching zero
    step("R8 en loc2", 0, 0, 0, 1, 3'd2, 2'd0, 32'h8000_0004, 3'd2);
    step("R8 loc2 event", 1, 3'd2, 4'h4, 0, 0, 0, 0, 3'd2);
    step("R8 loc2 clear drops shared", 0, 0, 0, 1, 3'd2, 2'd1, 32'h4, 3'd2);
    rd("R8 loc0 still set", 3'd0, 2'd1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] act, wl, el;
      logic [1:0] ws;
      logic [31:0] wd;
      act = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
      wl  = ($urandom % 3 == 0) ? 3'($urandom % 8) : act;
      el  = 3'($urandom % 6);
      ws  = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
      wd  = $urandom;
      if ($urandom % 2 == 0) wd[31] = 1'b1;
      step("R4 R8 random line", ($urandom % 2) == 1, el, 4'($urandom),
           ($urandom % 3) == 0, wl, ws, wd, act);
      rd("R3 R5 R7 random read", 3'($urandom % 6), 2'($urandom % 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule